// File: doc/BRIEF.md
# Interrupt Vector Fetch Controller

This block picks one interrupt source to service and reads that source's service-routine pointer from the vector table at the bottom of the 20-bit address space. There are four sources. Internally raised exceptions use a fixed vector number. Software interrupt instructions supply a vector number from the instruction. The non-maskable request always uses vector 2. The external maskable request supplies its own vector number and is honoured only while the interrupt-enable input is high.

When the controller is idle, it grants the highest-priority pending source. It then reads the four pointer bytes at vector×4 through a byte-wide request/acknowledge memory port, one byte at a time. From those bytes it assembles the new code segment and instruction pointer and the 20-bit physical entry address, and it flags completion with a single-cycle pulse. Pushing flags and the return address onto the stack is left to other logic.

Top module: `ivec_fetch_ctrl`

## Requirements
- R1: After reset, `mem_req`, `busy` and `done` are 0.
- R2: When several sources request in the same idle cycle, the winner is chosen in this order: exception first, then software interrupt, then non-maskable, then maskable.
- R3: A maskable request is not accepted while `int_en` is 0. The non-maskable request is accepted whatever the value of `int_en`.
- R4: The vector number depends on the source. An exception uses parameter `EXC_VEC` (default 0). A software interrupt uses `swi_vec`. The non-maskable request uses 2. The maskable request uses `int_vec`.
- R5: A fetch issues exactly four reads, at addresses vector×4+0, +1, +2 and +3, in that order. The first read is presented in the cycle after the request is accepted.
- R6: Byte 0 is the low half of `ip_out` and byte 1 is its high half. Byte 2 is the low half of `cs_out` and byte 3 is its high half.
- R7: `entry_addr` equals (`cs_out`×16 + `ip_out`) modulo 2^20. For example, CS 0726h with IP 16B4h gives 08914h.
- R8: `done` is high for exactly one cycle, the cycle after the fourth acknowledge is sampled. With w wait cycles before each acknowledge, that cycle is 4×(w+1) cycles after the accepting edge.
- R9: Requests that arrive while a fetch is in progress are ignored. They change neither the addresses read nor the result.
- R10: While an acknowledge is awaited, `mem_req` stays high and `mem_addr` holds its value.
- R11: `vec_out` reports the vector number of the fetch in progress or last completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Internal exception request |
| swi_req | input | 1 | Software interrupt request |
| swi_vec | input | 8 | Vector number from the software interrupt instruction |
| nmi_req | input | 1 | Non-maskable request |
| int_req | input | 1 | External maskable request |
| int_vec | input | 8 | Vector number supplied by the external device |
| int_en | input | 1 | Interrupt-enable flag gating maskable requests |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | 8 | Read data byte |
| busy | output | 1 | A fetch is in progress |
| done | output | 1 | One-cycle completion pulse |
| vec_out | output | 8 | Vector number being or last serviced |
| cs_out | output | 16 | Assembled code segment |
| ip_out | output | 16 | Assembled instruction pointer |
| entry_addr | output | 20 | Physical entry address |

## Verification
A request accepted at one edge shows up as `mem_req` and the first address in the following cycle. Each byte then takes w+1 cycles, so with w wait states `done` rises 4×(w+1) cycles after the accepting edge. `cs_out`, `ip_out` and `entry_addr` are valid from that same cycle. The bench drives its inputs and the memory acknowledge on falling edges and samples the outputs on falling edges. It counts falling edges from acceptance to `done` and compares the count with 4×(w+1)+1. It checks the result values and the logged read addresses in the `done` cycle, and checks that `done` has dropped one cycle later.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
    localparam int unsigned VEC_W       = 8;
    localparam int unsigned ADDR_W      = 20;
    localparam int unsigned WORD_W      = 16;
    localparam int unsigned ENTRY_BYTES = 4;
    localparam int unsigned BYTE_IDX_W  = $clog2(ENTRY_BYTES);
    localparam int unsigned NUM_SRC     = 4;

    // Source slots, lower index wins arbitration
    localparam int unsigned SRC_EXC = 0;
    localparam int unsigned SRC_SWI = 1;
    localparam int unsigned SRC_NMI = 2;
    localparam int unsigned SRC_INT = 3;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_READ = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e                          phase;
        logic [VEC_W-1:0]                vec;
        logic [BYTE_IDX_W-1:0]           idx;
        logic [ADDR_W-1:0]               addr;
        logic [ENTRY_BYTES-1:0][7:0]     bytes;
        logic                            done;
    } seq_state_t;
endpackage

// File: rtl/ivf_arbiter.sv
module ivf_arbiter
    import ivf_pkg::*;
#(
    parameter logic [VEC_W-1:0] EXC_VEC = 8'h00,
    parameter logic [VEC_W-1:0] NMI_VEC = 8'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             exc_req,
    input  logic             swi_req,
    input  logic [VEC_W-1:0] swi_vec,
    input  logic             nmi_req,
    input  logic             int_req,
    input  logic [VEC_W-1:0] int_vec,
    input  logic             int_en,
    output logic             grant_any,
    output logic [VEC_W-1:0] grant_vec
);
    logic [NUM_SRC-1:0]            raw;
    logic [NUM_SRC-1:0]            gnt;
    logic [NUM_SRC-1:0][VEC_W-1:0] src_vec;
    logic                          taken;

    always_comb begin
        raw[SRC_EXC]     = enable & exc_req;
        raw[SRC_SWI]     = enable & swi_req;
        raw[SRC_NMI]     = enable & nmi_req;
        raw[SRC_INT]     = enable & int_req & int_en;
        src_vec[SRC_EXC] = EXC_VEC;
        src_vec[SRC_SWI] = swi_vec;
        src_vec[SRC_NMI] = NMI_VEC;
        src_vec[SRC_INT] = int_vec;
    end

    always_comb begin
        taken     = 1'b0;
        gnt       = '0;
        grant_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            gnt[i]    = raw[i] & ~taken;
            taken     = taken | raw[i];
            grant_vec = grant_vec | (gnt[i] ? src_vec[i] : '0);
        end
        grant_any = taken;
    end

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_exc_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && exc_req) |-> gnt[SRC_EXC]);
    assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[SRC_INT] |-> int_en);
    assert_nmi_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && nmi_req && !exc_req && !swi_req) |-> (grant_any && grant_vec == NMI_VEC));
endmodule

// File: rtl/ivf_fetch_seq.sv
module ivf_fetch_seq
    import ivf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VEC_W-1:0]  start_vec,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic [VEC_W-1:0]  vec,
    output logic [WORD_W-1:0] cs,
    output logic [WORD_W-1:0] ip
);
    localparam logic [BYTE_IDX_W-1:0] LAST_IDX = BYTE_IDX_W'(ENTRY_BYTES - 1);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_READ;
                    st_d.vec   = start_vec;
                    st_d.idx   = '0;
                    st_d.addr  = ADDR_W'(start_vec) << BYTE_IDX_W;
                end
            end
            PH_READ: begin
                if (mem_ack) begin
                    st_d.bytes[st_q.idx] = mem_rdata;
                    if (st_q.idx == LAST_IDX) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.idx  = st_q.idx + 1'b1;
                        st_d.addr = st_q.addr + ADDR_W'(1);
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req  = (st_q.phase == PH_READ);
    assign busy     = (st_q.phase == PH_READ);
    assign mem_addr = st_q.addr;
    assign done     = st_q.done;
    assign vec      = st_q.vec;
    assign ip       = {st_q.bytes[1], st_q.bytes[0]};
    assign cs       = {st_q.bytes[3], st_q.bytes[2]};

    assert_hold_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_addr[BYTE_IDX_W-1:0] != LAST_IDX)
        |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1)));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
    assert_vec_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(vec));
endmodule

// File: rtl/ivf_entry_calc.sv
module ivf_entry_calc
    import ivf_pkg::*;
#(
    parameter int unsigned SEG_SHIFT = 4
) (
    input  logic [WORD_W-1:0] cs,
    input  logic [WORD_W-1:0] ip,
    output logic [ADDR_W-1:0] entry
);
    localparam int unsigned BASE_W = WORD_W + SEG_SHIFT;

    logic [BASE_W-1:0] seg_base;

    always_comb begin
        seg_base = {cs, {SEG_SHIFT{1'b0}}};
        entry    = ADDR_W'(seg_base) + ADDR_W'(ip);
    end
endmodule

// File: rtl/ivec_fetch_ctrl.sv
module ivec_fetch_ctrl
    import ivf_pkg::*;
#(
    parameter logic [VEC_W-1:0] EXC_VEC   = 8'h00,
    parameter logic [VEC_W-1:0] NMI_VEC   = 8'h02,
    parameter int unsigned      SEG_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              swi_req,
    input  logic [VEC_W-1:0]  swi_vec,
    input  logic              nmi_req,
    input  logic              int_req,
    input  logic [VEC_W-1:0]  int_vec,
    input  logic              int_en,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [VEC_W-1:0]  vec_out,
    output logic [WORD_W-1:0] cs_out,
    output logic [WORD_W-1:0] ip_out,
    output logic [ADDR_W-1:0] entry_addr
);
    logic             grant_any;
    logic [VEC_W-1:0] grant_vec;

    ivf_arbiter #(
        .EXC_VEC (EXC_VEC),
        .NMI_VEC (NMI_VEC)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (~busy),
        .exc_req   (exc_req),
        .swi_req   (swi_req),
        .swi_vec   (swi_vec),
        .nmi_req   (nmi_req),
        .int_req   (int_req),
        .int_vec   (int_vec),
        .int_en    (int_en),
        .grant_any (grant_any),
        .grant_vec (grant_vec)
    );

    ivf_fetch_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (grant_any),
        .start_vec (grant_vec),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done),
        .vec       (vec_out),
        .cs        (cs_out),
        .ip        (ip_out)
    );

    ivf_entry_calc #(
        .SEG_SHIFT (SEG_SHIFT)
    ) u_entry (
        .cs    (cs_out),
        .ip    (ip_out),
        .entry (entry_addr)
    );

    assert_first_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_any && !busy) |=> (mem_req && mem_addr == (ADDR_W'($past(grant_vec)) << BYTE_IDX_W)));
    assert_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> !mem_req);
endmodule

// File: tb/tb_ivec_fetch_ctrl.sv
module tb_ivec_fetch_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        exc_req, swi_req, nmi_req, int_req, int_en;
    logic [7:0]  swi_vec, int_vec;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_ack;
    logic [7:0]  mem_rdata;
    logic        busy, done;
    logic [7:0]  vec_out;
    logic [15:0] cs_out, ip_out;
    logic [19:0] entry_addr;

    int nchk  = 0;
    int nfail = 0;

    logic [7:0]  mem [0:1023];
    int          wait_n  = 0;
    int          ack_cnt = 0;
    int          nlog    = 0;
    logic [19:0] addr_log [0:7];

    ivec_fetch_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_req    (exc_req),
        .swi_req    (swi_req),
        .swi_vec    (swi_vec),
        .nmi_req    (nmi_req),
        .int_req    (int_req),
        .int_vec    (int_vec),
        .int_en     (int_en),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .vec_out    (vec_out),
        .cs_out     (cs_out),
        .ip_out     (ip_out),
        .entry_addr (entry_addr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory responder: acknowledges after wait_n idle cycles, logs each acked address
    always @(negedge clk) begin
        if (mem_req && ack_cnt >= wait_n) begin
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[9:0]];
            if (nlog < 8) addr_log[nlog] = mem_addr;
            nlog++;
            ack_cnt = 0;
        end else begin
            mem_ack = 1'b0;
            if (mem_req) ack_cnt++;
            else         ack_cnt = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_reqs();
        exc_req = 1'b0; swi_req = 1'b0; nmi_req = 1'b0; int_req = 1'b0;
    endtask

    // Called at a negedge with requests already driven
    task automatic fetch(input int exp_vec, input int w, input bit noise);
        int n;
        int base;
        bit held;
        logic [15:0] ip_e, cs_e;
        int ent;
        wait_n = w;
        nlog   = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R5 first read issued", {31'd0, mem_req}, 32'd1);
        chk("R5 first address", {12'd0, mem_addr}, exp_vec * 4);
        chk("R11 vector in flight", {24'd0, vec_out}, exp_vec);
        if (noise) begin
            exc_req = 1'b1; nmi_req = 1'b1;
            swi_req = 1'b1; swi_vec = ~8'(exp_vec);
        end else begin
            clear_reqs();
        end
        n = 1;
        held = 1'b1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            if (n == 3) clear_reqs();
            if (!done && !mem_req) held = 1'b0;
        end
        chk("R8 done latency", n, 4 * (w + 1) + 1);
        chk("R10 request held through waits", {31'd0, held}, 32'd1);
        chk("R5 read count", nlog, 4);
        base = exp_vec * 4;
        for (int k = 0; k < 4; k++)
            chk("R5 read address order", {12'd0, addr_log[k]}, base + k);
        ip_e = {mem[base + 1], mem[base]};
        cs_e = {mem[base + 3], mem[base + 2]};
        ent  = ((int'(cs_e) * 16) + int'(ip_e)) & 32'hFFFFF;
        chk("R6 ip assembly", {16'd0, ip_out}, {16'd0, ip_e});
        chk("R6 cs assembly", {16'd0, cs_out}, {16'd0, cs_e});
        chk("R7 entry address", {12'd0, entry_addr}, ent);
        chk("R11 vector reported", {24'd0, vec_out}, exp_vec);
        @(negedge clk);
        chk("R8 done single cycle", {31'd0, done}, 32'd0);
        chk("R9 no follow-on fetch", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++)
            mem[a] = 8'((a * 29 + 7) ^ (a >> 2));
        mem['h84] = 8'hB4; mem['h85] = 8'h16; mem['h86] = 8'h26; mem['h87] = 8'h07;
        mem_ack = 1'b0; mem_rdata = 8'h00;
        clear_reqs();
        swi_vec = 8'h00; int_vec = 8'h00; int_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: masked request is not taken
        int_en = 1'b0; int_req = 1'b1; int_vec = 8'h33;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk("R3 masked request ignored", {30'd0, busy, mem_req}, 32'd0);
        end
        // R3, R4: nmi taken even with int_en low, uses vector 2
        nmi_req = 1'b1;
        fetch(2, 0, 1'b0);

        // R4: maskable sweep over all vectors with varying wait states
        int_en = 1'b1;
        for (int v = 0; v < 256; v++) begin
            int_req = 1'b1; int_vec = 8'(v);
            fetch(v, v % 3, 1'b0);
        end
        // R4: software interrupt sweep
        for (int v = 0; v < 256; v++) begin
            swi_req = 1'b1; swi_vec = 8'(v);
            fetch(v, 0, 1'b0);
        end
        // R4: exception uses fixed vector 0
        exc_req = 1'b1;
        fetch(0, 1, 1'b0);

        // R2: priority
        exc_req = 1'b1; swi_req = 1'b1; swi_vec = 8'h40; nmi_req = 1'b1; int_req = 1'b1; int_vec = 8'h50;
        fetch(0, 0, 1'b0);
        swi_req = 1'b1; swi_vec = 8'h40; nmi_req = 1'b1; int_req = 1'b1; int_vec = 8'h50;
        fetch(8'h40, 0, 1'b0);
        nmi_req = 1'b1; int_req = 1'b1; int_vec = 8'h50;
        fetch(2, 0, 1'b0);

        // R7: known pointer 0726:16B4
        int_req = 1'b1; int_vec = 8'h21;
        fetch(8'h21, 0, 1'b0);
        chk("R7 example entry 08914", {12'd0, entry_addr}, 32'h08914);

        // R9: requests during fetch ignored; R10 with long waits
        int_req = 1'b1; int_vec = 8'h10;
        fetch(8'h10, 1, 1'b1);
        int_req = 1'b1; int_vec = 8'hFF;
        fetch(8'hFF, 3, 1'b1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule